// File: doc/BRIEF.md
# MMU Fault Status Capture Registers

This block sits beside the address translator of a segmented memory management unit and holds its three software-visible control registers. These are a control/status word, a fault-address register and a per-mode split-space control register. The translator reports each access violation as a one-cycle event. The event carries the abort causes, the segment number, the instruction/data space, the processor mode and a non-fatal trap indication. The block records the event and raises a one-cycle abort or trap request toward the processor.

An abort locks the recorded segment, space, mode and the fault address. This gives the fault handler a stable picture of the first failing access, however many accesses fail after it. The lock holds until software writes the status word with the abort flags cleared. The translation enable, the maintenance bit, the per-mode split-space enables and the 22-bit addressing enable are driven straight from the registers to the translator.

Software reaches the registers through a 16-bit port. A write takes effect at the clock edge. A read is combinational on the selected register.

Top module: `mmu_fault_status`

## Requirements
- R1: After a synchronous active-low reset, all three registers read 0. Every output is 0, so translation, split spaces and 22-bit addressing are disabled.
- R2: A write with select 0 loads the status word. Bits 11:10 always read 0, and every other bit reads back as written. Bit 0 drives `xlate_en` and bit 8 drives `maint_en`.
- R3: A fault event with any abort cause, arriving while no abort flag is set, does three things at the next edge. It ORs cause bit 2/1/0 into status bits 15/14/13 (non-resident, length, read-only). It loads bits 7:1 with {0, mode[1:0], space, segment[2:0]}. It drives `abort_req` high for exactly the following cycle.
- R4: While any of status bits 15:13 is set, further abort events leave bits 7:1 unchanged. New cause bits still OR into 15:13, and `abort_req` still pulses.
- R5: When `ifetch_start` is high and no abort flag is set, select 1 reads `ifetch_addr` after the edge. While frozen, and in the same cycle as an abort event, the fetch address is not taken.
- R6: A trap-only event (trap set, no abort cause) sets status bit 12 and pulses `trap_req` only when status bit 9 is 1. With bit 9 at 0 it has no effect. A trap never freezes the fault address. An event that has both an abort cause and a trap is handled as an abort only.
- R7: A status write takes precedence over a fault event in the same cycle, although `abort_req` still pulses. Writing the abort flags to 0 resumes fault-address capture on the next fetch.
- R8: Writes with select 1 are ignored, so the fault address is read-only.
- R9: A write with select 2 keeps bits 4 (22-bit enable), 2 (kernel), 1 (supervisor) and 0 (user). The other bits read 0. `split_en` carries bits 2:0 and `addr22_en` carries bit 4.
- R10: A read with select 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 status, 1 fault address, 2 split control |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| flt_valid | input | 1 | Translator reports a violation this cycle |
| flt_abort | input | 3 | Abort causes: [2] non-resident, [1] length, [0] read-only |
| flt_trap | input | 1 | Non-fatal trap condition |
| flt_seg | input | 3 | Segment number of the access |
| flt_dspace | input | 1 | 1 when the access used data space |
| flt_mode | input | 2 | Processor mode of the access |
| ifetch_start | input | 1 | An instruction fetch starts this cycle |
| ifetch_addr | input | 16 | Virtual address of that instruction |
| xlate_en | output | 1 | Translation enable |
| maint_en | output | 1 | Maintenance bit |
| split_en | output | 3 | Split I/D enables: [2] kernel, [1] supervisor, [0] user |
| addr22_en | output | 1 | 22-bit addressing enable |
| abort_req | output | 1 | One-cycle abort request |
| trap_req | output | 1 | One-cycle trap request |

## Verification
A wrong freeze state shows up at the ports one cycle after the next fault or fetch. If the freeze is stuck on, a new abort or fetch fails to change the status read or the fault-address read. If the freeze is stuck off, a second abort overwrites the recorded segment. A bad trap-enable path shows up in `trap_req` in the cycle after a trap-only event. The bench therefore mixes frequent fetches and faults with status writes that mostly clear the abort flags, and compares every read and request every cycle against its own register model.

// File: rtl/mmu_fs_pkg.sv
// Package: shared widths, status-word bit positions and register selects
// for the fault status capture block. Assumes a 16-bit register port.
package mmu_fs_pkg;
    localparam int DATA_W    = 16;
    localparam int SEG_W     = 3;
    localparam int MODE_W    = 2;
    localparam int NUM_MODES = 3;
    localparam int CAUSE_W   = 3;
    localparam int SEL_W     = 2;

    // status word bit positions
    localparam int ST_CAUSE_LO = 13;
    localparam int ST_CAUSE_HI = ST_CAUSE_LO + CAUSE_W - 1;
    localparam int ST_TRAP     = 12;
    localparam int ST_TRAP_EN  = 9;
    localparam int ST_MAINT    = 8;
    localparam int ST_SEG_LO   = 1;
    localparam int ST_SPACE    = ST_SEG_LO + SEG_W;
    localparam int ST_MODE_LO  = ST_SPACE + 1;
    localparam int ST_DONE     = ST_MODE_LO + MODE_W;
    localparam int ST_ENABLE   = 0;
    localparam int CAP_W       = ST_DONE - ST_SEG_LO + 1;

    // bits 11:10 are not implemented
    localparam logic [DATA_W-1:0] ST_WMASK = 16'hF3FF;

    // split control register
    localparam int SP_A22 = 4;

    // register selects
    localparam logic [SEL_W-1:0] SEL_STAT  = 2'd0;
    localparam logic [SEL_W-1:0] SEL_FADDR = 2'd1;
    localparam logic [SEL_W-1:0] SEL_SPLIT = 2'd2;
endpackage

// File: rtl/mmu_fs_status.sv
// Module: status word. It records abort causes and the segment, space and
// mode of the first abort. It sets the trap flag when traps are enabled and
// issues one-cycle abort and trap requests. Assumes that the translator
// reports at most one event per cycle and that a status write wins over an
// event in the same cycle.
module mmu_fs_status
    import mmu_fs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               evt_valid,
    input  logic [CAUSE_W-1:0] evt_abort,
    input  logic               evt_trap,
    input  logic [SEG_W-1:0]   evt_seg,
    input  logic               evt_dspace,
    input  logic [MODE_W-1:0]  evt_mode,
    output logic [DATA_W-1:0]  stat_q,
    output logic               frozen,
    output logic               abort_now,
    output logic               abort_req,
    output logic               trap_req
);
    logic              trap_now;
    logic [DATA_W-1:0] stat_d;

    // classify the incoming event
    always_comb begin
        abort_now = evt_valid && (|evt_abort);
        trap_now  = evt_valid && evt_trap && !abort_now && stat_q[ST_TRAP_EN];
        frozen    = |stat_q[ST_CAUSE_HI:ST_CAUSE_LO];
    end

    // next status word: software write first, then capture
    always_comb begin
        stat_d = stat_q;
        if (wr_en) begin
            stat_d = wdata & ST_WMASK;
        end else begin
            if (abort_now) begin
                stat_d[ST_CAUSE_HI:ST_CAUSE_LO] = stat_q[ST_CAUSE_HI:ST_CAUSE_LO] | evt_abort;
                if (!frozen)
                    stat_d[ST_DONE:ST_SEG_LO] = {1'b0, evt_mode, evt_dspace, evt_seg};
            end
            if (trap_now)
                stat_d[ST_TRAP] = 1'b1;
        end
    end

    // status register and request pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q    <= '0;
            abort_req <= 1'b0;
            trap_req  <= 1'b0;
        end else begin
            stat_q    <= stat_d;
            abort_req <= abort_now;
            trap_req  <= trap_now;
        end
    end
endmodule

// File: rtl/mmu_fs_faddr.sv
// Module: fault-address register. It follows the address of each fetched
// instruction until an abort freezes it. Software cannot write it. A fetch
// that coincides with an abort belongs to the next instruction and is
// dropped.
module mmu_fs_faddr
    import mmu_fs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_start,
    input  logic [DATA_W-1:0] fetch_addr,
    input  logic              frozen,
    input  logic              abort_now,
    output logic [DATA_W-1:0] faddr_q
);
    logic take;

    // a fetch address is accepted only while nothing is locked
    always_comb take = fetch_start && !frozen && !abort_now;

    // address register
    always_ff @(posedge clk) begin
        if (!rst_n)
            faddr_q <= '0;
        else if (take)
            faddr_q <= fetch_addr;
    end
endmodule

// File: rtl/mmu_fs_split.sv
// Module: split-space control. It holds one split I/D enable per processor
// mode and the 22-bit addressing enable. Assumes that the caller passes in
// only the implemented write bits.
module mmu_fs_split
    import mmu_fs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [NUM_MODES-1:0] wr_modes,
    input  logic                 wr_a22,
    output logic [NUM_MODES-1:0] split_q,
    output logic                 a22_q
);
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
        // per-mode split enable bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                split_q[m] <= 1'b0;
            else if (wr_en)
                split_q[m] <= wr_modes[m];
        end
    end

    // 22-bit addressing enable
    always_ff @(posedge clk) begin
        if (!rst_n)
            a22_q <= 1'b0;
        else if (wr_en)
            a22_q <= wr_a22;
    end
endmodule

// File: rtl/mmu_fault_status.sv
// Module: top of the fault status capture block. It decodes the register
// port, instantiates the status word, the fault address and the split
// control, and drives the control outputs to the translator. Reads are
// combinational on reg_sel.
module mmu_fault_status
    import mmu_fs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     reg_sel,
    input  logic                 reg_wr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 flt_valid,
    input  logic [CAUSE_W-1:0]   flt_abort,
    input  logic                 flt_trap,
    input  logic [SEG_W-1:0]     flt_seg,
    input  logic                 flt_dspace,
    input  logic [MODE_W-1:0]    flt_mode,
    input  logic                 ifetch_start,
    input  logic [DATA_W-1:0]    ifetch_addr,
    output logic                 xlate_en,
    output logic                 maint_en,
    output logic [NUM_MODES-1:0] split_en,
    output logic                 addr22_en,
    output logic                 abort_req,
    output logic                 trap_req
);
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] faddr_q;
    logic              frozen;
    logic              abort_now;
    logic              wr_stat;
    logic              wr_split;
    logic [DATA_W-1:0] split_rd;

    // write strobes per register; select 1 has none
    always_comb begin
        wr_stat  = reg_wr && (reg_sel == SEL_STAT);
        wr_split = reg_wr && (reg_sel == SEL_SPLIT);
    end

    mmu_fs_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_stat),
        .wdata      (reg_wdata),
        .evt_valid  (flt_valid),
        .evt_abort  (flt_abort),
        .evt_trap   (flt_trap),
        .evt_seg    (flt_seg),
        .evt_dspace (flt_dspace),
        .evt_mode   (flt_mode),
        .stat_q     (stat_q),
        .frozen     (frozen),
        .abort_now  (abort_now),
        .abort_req  (abort_req),
        .trap_req   (trap_req)
    );

    mmu_fs_faddr u_faddr (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_start (ifetch_start),
        .fetch_addr  (ifetch_addr),
        .frozen      (frozen),
        .abort_now   (abort_now),
        .faddr_q     (faddr_q)
    );

    mmu_fs_split u_split (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_split),
        .wr_modes (reg_wdata[NUM_MODES-1:0]),
        .wr_a22   (reg_wdata[SP_A22]),
        .split_q  (split_en),
        .a22_q    (addr22_en)
    );

    // control outputs taken from the status word
    always_comb begin
        xlate_en = stat_q[ST_ENABLE];
        maint_en = stat_q[ST_MAINT];
    end

    // assemble the split register image
    always_comb begin
        split_rd                   = '0;
        split_rd[NUM_MODES-1:0]    = split_en;
        split_rd[SP_A22]           = addr22_en;
    end

    // read multiplexer
    always_comb begin
        case (reg_sel)
            SEL_STAT:  reg_rdata = stat_q;
            SEL_FADDR: reg_rdata = faddr_q;
            SEL_SPLIT: reg_rdata = split_rd;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mmu_fault_status_chk.sv
// Checker: temporal properties of the fault status block, bound to the top.
module mmu_fault_status_chk
    import mmu_fs_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [SEL_W-1:0]     reg_sel,
    input logic                 reg_wr,
    input logic [NUM_MODES-1:0] wr_split_bits,
    input logic                 flt_valid,
    input logic [CAUSE_W-1:0]   flt_abort,
    input logic                 ifetch_start,
    input logic                 abort_req,
    input logic                 trap_req,
    input logic [NUM_MODES-1:0] split_en,
    input logic [CAUSE_W-1:0]   cause_flags,
    input logic                 trap_en,
    input logic [CAP_W-1:0]     cap_fields,
    input logic [DATA_W-1:0]    faddr_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (cause_flags == '0 && cap_fields == '0 && faddr_q == '0));

    // R3
    abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && |flt_abort) |=> abort_req);

    // R3
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flt_valid && |flt_abort) |=> !abort_req);

    // R4
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|cause_flags) && !(reg_wr && reg_sel == SEL_STAT)) |=> $stable(cap_fields));

    // R5
    faddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cause_flags) |=> $stable(faddr_q));

    // R6
    trap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(trap_en));

    // R8
    faddr_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_FADDR && !ifetch_start) |=> $stable(faddr_q));

    // R9
    split_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_SPLIT) |=> (split_en == $past(wr_split_bits)));
endmodule

bind mmu_fault_status mmu_fault_status_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_sel       (reg_sel),
    .reg_wr        (reg_wr),
    .wr_split_bits (reg_wdata[2:0]),
    .flt_valid     (flt_valid),
    .flt_abort     (flt_abort),
    .ifetch_start  (ifetch_start),
    .abort_req     (abort_req),
    .trap_req      (trap_req),
    .split_en      (split_en),
    .cause_flags   (stat_q[15:13]),
    .trap_en       (stat_q[9]),
    .cap_fields    (stat_q[7:1]),
    .faddr_q       (faddr_q)
);

// File: tb/mmu_fault_status_test.sv
`timescale 1ns/1ps
module mmu_fault_status_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  reg_sel;
    logic        reg_wr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        flt_valid;
    logic [2:0]  flt_abort;
    logic        flt_trap;
    logic [2:0]  flt_seg;
    logic        flt_dspace;
    logic [1:0]  flt_mode;
    logic        ifetch_start;
    logic [15:0] ifetch_addr;
    logic        xlate_en, maint_en, addr22_en, abort_req, trap_req;
    logic [2:0]  split_en;

    int tests = 0;
    int fails = 0;
    int unsigned seed_val;

    // expected-state model
    logic [15:0] m_stat, m_faddr;
    logic [4:0]  m_split;
    logic        m_abort, m_trap;

    always #10 clk = ~clk;

    mmu_fault_status uut (.*);

    // model update from the requirements
    always @(posedge clk) begin
        logic ab, tr, fz;
        if (!rst_n) begin
            m_stat <= 16'h0; m_faddr <= 16'h0; m_split <= 5'h0;
            m_abort <= 1'b0; m_trap <= 1'b0;
        end else begin
            ab = flt_valid && (flt_abort != 3'b0);
            tr = flt_valid && flt_trap && !ab && m_stat[9];
            fz = m_stat[15:13] != 3'b0;
            m_abort <= ab;
            m_trap  <= tr;
            if (reg_wr && reg_sel == 2'd0)
                m_stat <= reg_wdata & 16'hF3FF;
            else begin
                logic [15:0] s;
                s = m_stat;
                if (ab) begin
                    s[15:13] = s[15:13] | flt_abort;
                    if (!fz) s[7:1] = {1'b0, flt_mode, flt_dspace, flt_seg};
                end
                if (tr) s[12] = 1'b1;
                m_stat <= s;
            end
            if (ifetch_start && !fz && !ab) m_faddr <= ifetch_addr;
            if (reg_wr && reg_sel == 2'd2) m_split <= {reg_wdata[4], 1'b0, reg_wdata[2:0]};
        end
    end

    function automatic logic [15:0] model_rd(input logic [1:0] sel);
        case (sel)
            2'd0: return m_stat;
            2'd1: return m_faddr;
            2'd2: return {11'h0, m_split};
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        reg_wr = 0; flt_valid = 0; flt_abort = 0; flt_trap = 0; ifetch_start = 0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] v);
        reg_sel = sel; #1; v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        reg_sel = sel; reg_wr = 1; reg_wdata = d; step(); idle();
    endtask

    task automatic fault(input logic [2:0] ab, input logic tr, input logic [2:0] sg,
                         input logic [1:0] md, input logic ds);
        flt_valid = 1; flt_abort = ab; flt_trap = tr; flt_seg = sg; flt_mode = md; flt_dspace = ds;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        seed_val = $urandom(32'h5EED);
        rst_n = 0; reg_sel = 0; reg_wdata = 0; flt_seg = 0; flt_mode = 0; flt_dspace = 0;
        ifetch_addr = 0; idle();
        repeat (3) step();
        rst_n = 1;
        // R1 reset state
        rd(0, v); chk("R1 status", v, 16'h0);
        rd(1, v); chk("R1 faddr", v, 16'h0);
        rd(2, v); chk("R1 split", v, 16'h0);
        chk("R1 outputs", {10'h0, xlate_en, maint_en, split_en, addr22_en}, 16'h0);
        // R2 status write/read
        wr(0, 16'hFFFF); rd(0, v); chk("R2 mask", v, 16'hF3FF);
        wr(0, 16'h0301); rd(0, v); chk("R2 readback", v, 16'h0301);
        chk("R2 enables", {14'h0, xlate_en, maint_en}, 16'h3);
        // R5 fetch address follows
        wr(0, 16'h0200);
        ifetch_start = 1; ifetch_addr = 16'h1234; step(); idle();
        rd(1, v); chk("R5 follow", v, 16'h1234);
        // R3 first abort capture
        fault(3'b100, 0, 3'd5, 2'b11, 1); step();
        chk("R3 abort_req", {15'h0, abort_req}, 16'h1); idle();
        rd(0, v); chk("R3 capture", v, 16'h827A);
        step(); chk("R3 pulse end", {15'h0, abort_req}, 16'h0);
        // R4 frozen
        fault(3'b001, 0, 3'd2, 2'b00, 0); ifetch_start = 1; ifetch_addr = 16'h5678; step();
        chk("R4 abort_req", {15'h0, abort_req}, 16'h1); idle();
        rd(0, v); chk("R4 frozen fields", v, 16'hA27A);
        rd(1, v); chk("R5 frozen faddr", v, 16'h1234);
        // R6 trap while enabled
        fault(3'b000, 1, 3'd0, 2'b00, 0); step();
        chk("R6 trap_req", {15'h0, trap_req}, 16'h1); idle();
        rd(0, v); chk("R6 trap flag", v, 16'hB27A);
        // R8 faddr read-only
        wr(1, 16'hFFFF); rd(1, v); chk("R8 ignore write", v, 16'h1234);
        // R7 write wins over same-cycle fault, capture resumes
        reg_sel = 0; reg_wr = 1; reg_wdata = 16'h0200; fault(3'b010, 0, 3'd7, 2'b01, 1); step();
        chk("R7 abort_req", {15'h0, abort_req}, 16'h1); idle();
        rd(0, v); chk("R7 write wins", v, 16'h0200);
        ifetch_start = 1; ifetch_addr = 16'h0ABC; step(); idle();
        rd(1, v); chk("R7 resume", v, 16'h0ABC);
        // R6 trap does not freeze
        fault(3'b000, 1, 3'd1, 2'b00, 0); step(); idle();
        ifetch_start = 1; ifetch_addr = 16'h3333; step(); idle();
        rd(1, v); chk("R6 no freeze", v, 16'h3333);
        // R6 trap disabled
        wr(0, 16'h0000);
        fault(3'b000, 1, 3'd1, 2'b00, 0); step();
        chk("R6 gated trap_req", {15'h0, trap_req}, 16'h0); idle();
        rd(0, v); chk("R6 gated flag", v, 16'h0000);
        // R5 fetch in abort cycle dropped
        fault(3'b100, 0, 3'd0, 2'b00, 0); ifetch_start = 1; ifetch_addr = 16'h2222; step(); idle();
        rd(1, v); chk("R5 same-cycle fetch", v, 16'h3333);
        wr(0, 16'h0000);
        // R9 split control, R10 unused select
        wr(2, 16'hFFFF); rd(2, v); chk("R9 mask", v, 16'h0017);
        chk("R9 outputs", {12'h0, addr22_en, split_en}, 16'h000F);
        wr(2, 16'h0005); rd(2, v); chk("R9 readback", v, 16'h0005);
        chk("R9 outputs2", {12'h0, addr22_en, split_en}, 16'h0005);
        rd(3, v); chk("R10 select 3", v, 16'h0);

        // constrained random phase against the model
        for (int i = 0; i < 4000; i++) begin
            reg_sel   = 2'($urandom % 4);
            reg_wr    = ($urandom % 8) == 0;
            reg_wdata = 16'($urandom);
            if (reg_sel == 2'd0 && ($urandom % 4) != 0) reg_wdata[15:13] = 3'b0;
            flt_valid  = ($urandom % 5) == 0;
            flt_abort  = (($urandom % 3) == 0) ? 3'($urandom) : 3'b0;
            flt_trap   = 1'($urandom);
            flt_seg    = 3'($urandom);
            flt_mode   = 2'($urandom);
            flt_dspace = 1'($urandom);
            ifetch_start = ($urandom % 3) == 0;
            ifetch_addr  = 16'($urandom);
            #1;
            case (reg_sel)
                2'd0: chk("R2 random status", reg_rdata, model_rd(reg_sel));
                2'd1: chk("R5 random faddr", reg_rdata, model_rd(reg_sel));
                2'd2: chk("R9 random split", reg_rdata, model_rd(reg_sel));
                default: chk("R10 random sel3", reg_rdata, model_rd(reg_sel));
            endcase
            step();
            chk("R3 random abort_req", {15'h0, abort_req}, {15'h0, m_abort});
            chk("R6 random trap_req", {15'h0, trap_req}, {15'h0, m_trap});
            chk("R9 random outputs", {12'h0, addr22_en, split_en}, {11'h0, m_split[4], m_split[2:0]});
            chk("R2 random enables", {14'h0, xlate_en, maint_en}, {14'h0, m_stat[0], m_stat[8]});
        end
        idle();
        step();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule